// File: doc/BRIEF.md
# Context Migration Scoreboard

This block sits next to a core's register file and private caches and decides which pieces of a running thread's context have to travel when the thread moves to another core. It watches register writes, reported at writeback or commit, and keeps two dirty bits per logical register. It also watches instruction-cache and data-cache touches and keeps a saturating age per block. When a migration starts, it turns these bits into a stream of labelled items, one per cycle. Each item names a register or a cache block. A separate unit uses the label to fetch the data and to place it correctly on the receiving core.

A migration has two phases. In the soft phase the thread keeps running. The registers modified before the migration started are sent, followed by the cache blocks touched within a programmable window. Registers written during the soft phase are recorded in the second dirty bit. The hard phase starts once the pipeline has been flushed. It sends those late-written registers, any items left over from the soft phase, and then raises a done strobe.

Top module: `ctx_mig_scoreboard`

## Requirements
- R1: While reset is held, and in the idle phase after it, outValid and migDone are 0 and outKind is 0.
- R2: A register written in the idle phase is marked dirty. After softStart, each dirty register appears on the output exactly once, one per cycle, in ascending index order, with outKind = 1 (register).
- R3: A register written during the soft phase is sent again in the hard phase. This includes a register written in the same cycle in which the soft phase sends it. The hard phase sends these registers in ascending order.
- R4: hardStart is honoured only in the soft phase, and softStart only in the idle phase. In any other phase each of them produces no output and no done strobe.
- R5: Registers still waiting when hardStart arrives are sent in the hard phase, and none is lost.
- R6: A cache block is selected when it has been touched and k < windowLen. Here k is the number of idle cycles between the cycle of its last touch and the softStart cycle. windowLen = 0 selects no block. The selection is frozen when softStart is accepted, so later touches do not change it.
- R7: Within a phase, all registers come before instruction blocks (outKind = 2), and instruction blocks come before data blocks (outKind = 3). Each group is sent in ascending index order.
- R8: migDone is high for exactly one cycle, in the hard phase once nothing remains to send. outValid is 0 in that cycle, and the block then returns to idle.
- R9: Register writes during the hard phase are ignored, so the next migration does not send those registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| windowLen | input | AGE_W | Touch window in cycles; 0 disables cache block selection |
| regWrValid | input | 1 | A register write retires this cycle |
| regWrIdx | input | log2(NUM_REGS) | Logical register written |
| iTouchValid | input | 1 | An instruction-cache block is touched this cycle |
| iTouchIdx | input | log2(NUM_BLOCKS) | Instruction-cache block touched |
| dTouchValid | input | 1 | A data-cache block is touched this cycle |
| dTouchIdx | input | log2(NUM_BLOCKS) | Data-cache block touched |
| softStart | input | 1 | Start a migration while the thread runs |
| hardStart | input | 1 | Pipeline is flushed; finish the migration |
| outValid | output | 1 | An item is offered this cycle |
| outKind | output | 2 | Item label: 1 register, 2 instruction block, 3 data block |
| outIdx | output | max of index widths | Index of the item |
| migDone | output | 1 | One-cycle strobe at the end of the hard phase |

## Verification
The bench builds the block with 8 registers, 4 blocks per cache and a 4-bit age. With this configuration every one of the 256 register dirty patterns can be streamed and compared. The age counters also saturate within 15 cycles, so stale touches can be aged out between scenarios. A sweep over windowLen and the touch-to-start distance, both from 0 to 5, covers each side of the window comparison. Directed sequences cover a write that lands on the register being sent, a hard start that cuts the soft phase short, writes during the hard phase, and start strobes given in the wrong phase.

// File: rtl/ctx_mig_pkg.sv
package ctx_mig_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SOFT = 2'd1,
    PH_HARD = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_REG  = 2'd1,
    KIND_IBLK = 2'd2,
    KIND_DBLK = 2'd3
  } kind_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic startSoft;
    logic inSoft;
    logic inHard;
    logic sendReg;
    logic sendIBlk;
    logic sendDBlk;
  } strobes_t;

endpackage

// File: rtl/mig_lowest_set.sv
module mig_lowest_set #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] idx,
  output logic         any
);
  // descending scan: the last hit written is the lowest set index
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mig_touch_window.sv
module mig_touch_window #(
  parameter int NUM_BLOCKS = 16,
  parameter int AGE_W      = 8,
  parameter int BLK_W      = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  touchValid,
  input  logic [BLK_W-1:0]      touchIdx,
  input  logic [AGE_W-1:0]      windowLen,
  output logic [NUM_BLOCKS-1:0] marked
);
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : gBlk
    logic [AGE_W-1:0] age;
    logic             seen;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        age  <= '0;
        seen <= 1'b0;
      end else if (touchValid && touchIdx == BLK_W'(b)) begin
        age  <= '0;
        seen <= 1'b1;
      end else if (age != '1) begin
        age <= age + 1'b1;
      end
    end
    assign marked[b] = seen && (age < windowLen);
  end
endmodule

// File: rtl/mig_control.sv
module mig_control
  import ctx_mig_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     softStart,
  input  logic     hardStart,
  input  logic     softRegAny,
  input  logic     hardRegAny,
  input  logic     iAny,
  input  logic     dAny,
  output strobes_t st,
  output phase_e   phase,
  output logic     migDone
);
  phase_e phaseNext;
  logic   regWant;
  logic   active;

  always_comb begin
    st.inSoft    = (phase == PH_SOFT);
    st.inHard    = (phase == PH_HARD);
    st.startSoft = (phase == PH_IDLE) && softStart;
    active       = st.inSoft || st.inHard;
    regWant      = (st.inSoft && softRegAny) || (st.inHard && hardRegAny);
    st.sendReg   = regWant;
    st.sendIBlk  = active && !regWant && iAny;
    st.sendDBlk  = active && !regWant && !iAny && dAny;
    migDone      = st.inHard && !hardRegAny && !iAny && !dAny;
    phaseNext    = phase;
    case (phase)
      PH_IDLE: if (softStart) phaseNext = PH_SOFT;
      PH_SOFT: if (hardStart) phaseNext = PH_HARD;
      PH_HARD: if (migDone)   phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end
endmodule

// File: rtl/mig_datapath.sv
module mig_datapath
  import ctx_mig_pkg::*;
#(
  parameter int NUM_REGS   = 32,
  parameter int NUM_BLOCKS = 16,
  parameter int AGE_W      = 8,
  parameter int REG_W      = 5,
  parameter int BLK_W      = 4,
  parameter int IDX_W      = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         st,
  input  logic             regWrValid,
  input  logic [REG_W-1:0] regWrIdx,
  input  logic             iTouchValid,
  input  logic [BLK_W-1:0] iTouchIdx,
  input  logic             dTouchValid,
  input  logic [BLK_W-1:0] dTouchIdx,
  input  logic [AGE_W-1:0] windowLen,
  output logic             softRegAny,
  output logic             hardRegAny,
  output logic             iAny,
  output logic             dAny,
  output logic             outValid,
  output logic [1:0]       outKind,
  output logic [IDX_W-1:0] outIdx
);
  logic [NUM_REGS-1:0]   dirtyA, dirtyB, regCand;
  logic [NUM_BLOCKS-1:0] iMask, dMask, iMarked, dMarked;
  logic [REG_W-1:0]      regSel;
  logic [BLK_W-1:0]      iSel, dSel;
  logic                  regCandAny;

  mig_touch_window #(.NUM_BLOCKS(NUM_BLOCKS), .AGE_W(AGE_W), .BLK_W(BLK_W)) uIWin (
    .clk(clk), .rstN(rstN), .touchValid(iTouchValid), .touchIdx(iTouchIdx),
    .windowLen(windowLen), .marked(iMarked));
  mig_touch_window #(.NUM_BLOCKS(NUM_BLOCKS), .AGE_W(AGE_W), .BLK_W(BLK_W)) uDWin (
    .clk(clk), .rstN(rstN), .touchValid(dTouchValid), .touchIdx(dTouchIdx),
    .windowLen(windowLen), .marked(dMarked));

  // the hard phase also drains anything the soft phase left behind
  assign regCand = st.inHard ? (dirtyA | dirtyB) : dirtyA;

  mig_lowest_set #(.N(NUM_REGS),   .W(REG_W)) uRegEnc (.vec(regCand), .idx(regSel), .any(regCandAny));
  mig_lowest_set #(.N(NUM_BLOCKS), .W(BLK_W)) uIEnc   (.vec(iMask),   .idx(iSel),   .any(iAny));
  mig_lowest_set #(.N(NUM_BLOCKS), .W(BLK_W)) uDEnc   (.vec(dMask),   .idx(dSel),   .any(dAny));

  assign softRegAny = |dirtyA;
  assign hardRegAny = |(dirtyA | dirtyB);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirtyA <= '0;
      dirtyB <= '0;
    end else begin
      if (st.sendReg) begin
        dirtyA[regSel] <= 1'b0;
        if (st.inHard) dirtyB[regSel] <= 1'b0;
      end
      if (regWrValid && !st.inSoft && !st.inHard) dirtyA[regWrIdx] <= 1'b1;
      if (regWrValid && st.inSoft)                dirtyB[regWrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iMask <= '0;
      dMask <= '0;
    end else if (st.startSoft) begin
      iMask <= iMarked;
      dMask <= dMarked;
    end else begin
      if (st.sendIBlk) iMask[iSel] <= 1'b0;
      if (st.sendDBlk) dMask[dSel] <= 1'b0;
    end
  end

  always_comb begin
    outValid = st.sendReg || st.sendIBlk || st.sendDBlk;
    outKind  = KIND_NONE;
    outIdx   = '0;
    if (st.sendReg) begin
      outKind = KIND_REG;
      outIdx  = IDX_W'(regSel);
    end else if (st.sendIBlk) begin
      outKind = KIND_IBLK;
      outIdx  = IDX_W'(iSel);
    end else if (st.sendDBlk) begin
      outKind = KIND_DBLK;
      outIdx  = IDX_W'(dSel);
    end
  end

  logic unusedAny;
  assign unusedAny = regCandAny;
endmodule

// File: rtl/ctx_mig_scoreboard.sv
module ctx_mig_scoreboard
  import ctx_mig_pkg::*;
#(
  parameter int NUM_REGS   = 32,
  parameter int NUM_BLOCKS = 64,
  parameter int AGE_W      = 10,
  localparam int REG_W     = $clog2(NUM_REGS),
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int IDX_W     = (REG_W > BLK_W) ? REG_W : BLK_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AGE_W-1:0] windowLen,
  input  logic             regWrValid,
  input  logic [REG_W-1:0] regWrIdx,
  input  logic             iTouchValid,
  input  logic [BLK_W-1:0] iTouchIdx,
  input  logic             dTouchValid,
  input  logic [BLK_W-1:0] dTouchIdx,
  input  logic             softStart,
  input  logic             hardStart,
  output logic             outValid,
  output logic [1:0]       outKind,
  output logic [IDX_W-1:0] outIdx,
  output logic             migDone
);
  strobes_t st;
  phase_e   phase;
  logic     softRegAny, hardRegAny, iAny, dAny;

  mig_control uCtrl (
    .clk(clk), .rstN(rstN), .softStart(softStart), .hardStart(hardStart),
    .softRegAny(softRegAny), .hardRegAny(hardRegAny), .iAny(iAny), .dAny(dAny),
    .st(st), .phase(phase), .migDone(migDone));

  mig_datapath #(
    .NUM_REGS(NUM_REGS), .NUM_BLOCKS(NUM_BLOCKS), .AGE_W(AGE_W),
    .REG_W(REG_W), .BLK_W(BLK_W), .IDX_W(IDX_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .st(st),
    .regWrValid(regWrValid), .regWrIdx(regWrIdx),
    .iTouchValid(iTouchValid), .iTouchIdx(iTouchIdx),
    .dTouchValid(dTouchValid), .dTouchIdx(dTouchIdx),
    .windowLen(windowLen),
    .softRegAny(softRegAny), .hardRegAny(hardRegAny), .iAny(iAny), .dAny(dAny),
    .outValid(outValid), .outKind(outKind), .outIdx(outIdx));
endmodule

// File: rtl/mig_scoreboard_checker.sv
module mig_scoreboard_checker
  import ctx_mig_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       outValid,
  input logic [1:0] outKind,
  input logic       migDone,
  input phase_e     phase
);
  localparam logic [1:0] KREG = 2'd1;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> (!outValid && !migDone));

  assert_hard_after_soft_R4: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HARD) |-> ($past(phase) != PH_IDLE));

  assert_regs_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind != KREG) |=> !(outValid && outKind == KREG && phase == $past(phase)));

  assert_done_no_item_R8: assert property (@(posedge clk) disable iff (!rstN)
    migDone |-> !outValid);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    migDone |=> (!migDone && phase == PH_IDLE));
endmodule

bind ctx_mig_scoreboard mig_scoreboard_checker uChk (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outKind(outKind),
  .migDone(migDone), .phase(phase));

// File: tb/sim_ctx_mig_scoreboard.sv
`timescale 1ns/1ps
module sim_ctx_mig_scoreboard;
  localparam int NR = 8;
  localparam int NB = 4;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] windowLen;
  logic          regWrValid, iTouchValid, dTouchValid, softStart, hardStart;
  logic [2:0]    regWrIdx;
  logic [1:0]    iTouchIdx, dTouchIdx;
  logic          outValid, migDone;
  logic [1:0]    outKind;
  logic [2:0]    outIdx;

  int checks = 0;
  int fails  = 0;
  int expK [64];
  int expI [64];
  int expN;

  always #5 clk = ~clk;

  ctx_mig_scoreboard #(.NUM_REGS(NR), .NUM_BLOCKS(NB), .AGE_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .windowLen(windowLen),
    .regWrValid(regWrValid), .regWrIdx(regWrIdx),
    .iTouchValid(iTouchValid), .iTouchIdx(iTouchIdx),
    .dTouchValid(dTouchValid), .dTouchIdx(dTouchIdx),
    .softStart(softStart), .hardStart(hardStart),
    .outValid(outValid), .outKind(outKind), .outIdx(outIdx), .migDone(migDone));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeReg(input int r);
    regWrValid = 1'b1; regWrIdx = 3'(r);
    @(negedge clk);
    regWrValid = 1'b0;
  endtask

  task automatic pulseSoft();
    softStart = 1'b1;
    @(negedge clk);
    softStart = 1'b0;
  endtask

  task automatic pulseHard();
    hardStart = 1'b1;
    @(negedge clk);
    hardStart = 1'b0;
  endtask

  task automatic addExp(input int k, input int i);
    expK[expN] = k; expI[expN] = i; expN++;
  endtask

  // items coded as kind*100+index in messages
  task automatic expectStream(input string req);
    for (int n = 0; n < expN; n++) begin
      chk(outValid && int'(outKind) == expK[n] && int'(outIdx) == expI[n], req,
          outValid ? int'(outKind) * 100 + int'(outIdx) : -1, expK[n] * 100 + expI[n]);
      @(negedge clk);
    end
  endtask

  task automatic finishHard(input string req);
    pulseHard();
    chk(migDone && !outValid, req, int'(migDone), 1);
    @(negedge clk);
    chk(!migDone && !outValid, "R8 done single cycle", int'(migDone), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rstN = 1'b0; windowLen = '0; regWrValid = 0; regWrIdx = '0;
    iTouchValid = 0; iTouchIdx = '0; dTouchValid = 0; dTouchIdx = '0;
    softStart = 0; hardStart = 0;
    idle(3);
    chk(!outValid && !migDone && outKind == 2'd0, "R1 in reset", int'(outValid), 0);
    rstN = 1'b1;
    idle(2);
    chk(!outValid && !migDone && outKind == 2'd0, "R1 after reset", int'(outValid), 0);

    // R2 every dirty pattern, R8 done after an empty hard phase
    for (int mask = 0; mask < 256; mask++) begin
      expN = 0;
      for (int r = 0; r < NR; r++) if (mask[r]) begin writeReg(r); addExp(1, r); end
      pulseSoft();
      expectStream("R2 soft register stream");
      chk(!outValid, "R2 soft drained", int'(outValid), 0);
      finishHard("R8 done after hard");
    end

    // R3 write during soft, including the register being sent
    writeReg(3);
    pulseSoft();
    chk(outValid && outKind == 2'd1 && outIdx == 3'd3, "R3 soft sends r3", int'(outIdx), 3);
    regWrValid = 1'b1; regWrIdx = 3'd3;
    @(negedge clk);
    regWrValid = 1'b0;
    chk(!outValid, "R3 soft drained", int'(outValid), 0);
    writeReg(6); writeReg(1);
    hardStart = 1'b1; @(negedge clk); hardStart = 1'b0;
    expN = 0; addExp(1, 1); addExp(1, 3); addExp(1, 6);
    expectStream("R3 hard resend");
    chk(migDone, "R8 done after R3", int'(migDone), 1);
    idle(2);

    // R5 hard start cuts soft short, R9 writes during hard ignored
    for (int r = 0; r < 5; r++) writeReg(r);
    pulseSoft();
    chk(outValid && outIdx == 3'd0, "R5 first soft item", int'(outIdx), 0);
    hardStart = 1'b1; @(negedge clk); hardStart = 1'b0;
    chk(outValid && outKind == 2'd1 && outIdx == 3'd1, "R5 leftover r1", int'(outIdx), 1);
    regWrValid = 1'b1; regWrIdx = 3'd7;
    @(negedge clk);
    regWrValid = 1'b0;
    expN = 0; addExp(1, 2); addExp(1, 3); addExp(1, 4);
    expectStream("R5 leftover stream");
    chk(migDone && !outValid, "R8 done after R5", int'(migDone), 1);
    idle(2);
    pulseSoft();
    chk(!outValid, "R9 hard write not kept", int'(outValid), 0);
    finishHard("R9 empty migration done");

    // R4 hard start in idle ignored
    pulseHard();
    for (int i = 0; i < 3; i++) begin
      chk(!outValid && !migDone, "R4 hard in idle ignored", int'(outValid | migDone), 0);
      @(negedge clk);
    end
    // R4 soft start during soft ignored (would recapture a fresh touch)
    idle(20);
    windowLen = 4'd8;
    writeReg(2);
    pulseSoft();
    chk(outValid && outIdx == 3'd2, "R4 soft item r2", int'(outIdx), 2);
    iTouchValid = 1'b1; iTouchIdx = 2'd0;
    @(negedge clk);
    iTouchValid = 1'b0;
    pulseSoft();
    chk(!outValid, "R4 soft restart ignored", int'(outValid), 0);
    finishHard("R4 done");

    // R6 window sweep
    for (int w = 0; w < 6; w++) begin
      for (int k = 0; k < 6; k++) begin
        idle(20);
        windowLen = AW'(w);
        iTouchValid = 1; iTouchIdx = 2'd1; dTouchValid = 1; dTouchIdx = 2'd2;
        regWrValid = 1; regWrIdx = 3'd5;
        @(negedge clk);
        iTouchValid = 0; dTouchValid = 0; regWrValid = 0;
        idle(k);
        pulseSoft();
        expN = 0; addExp(1, 5);
        if (k < w) begin addExp(2, 1); addExp(3, 2); end
        expectStream("R6 window selection");
        chk(!outValid, "R6 no extra block", int'(outValid), 0);
        finishHard("R6 done");
      end
    end

    // R7 ordering regs, instruction blocks, data blocks
    idle(20);
    windowLen = 4'd8;
    iTouchValid = 1; iTouchIdx = 2'd3; dTouchValid = 1; dTouchIdx = 2'd3;
    regWrValid = 1; regWrIdx = 3'd6;
    @(negedge clk);
    iTouchIdx = 2'd0; dTouchIdx = 2'd1; regWrIdx = 3'd2;
    @(negedge clk);
    iTouchValid = 0; dTouchValid = 0; regWrValid = 0;
    pulseSoft();
    expN = 0;
    addExp(1, 2); addExp(1, 6); addExp(2, 0); addExp(2, 3); addExp(3, 1); addExp(3, 3);
    expectStream("R7 order");
    iTouchValid = 1; iTouchIdx = 2'd2;
    @(negedge clk);
    iTouchValid = 0;
    chk(!outValid, "R6 touch during soft not added", int'(outValid), 0);
    finishHard("R7 done");

    idle(3);
    summary();
  end
endmodule